// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drains a circular list of transmit buffer descriptors held in word-addressed memory and turns the buffers they point at into a byte stream for a downstream MAC. Software prepares descriptors, marks them ready, and then pulses a kick input. The kick only counts while the controller enable input is high. On an accepted kick the engine reads descriptors one after another. For each ready descriptor it streams the referenced bytes out, then hands the descriptor back by rewriting its first word with the ready bit cleared. It then moves to the following descriptor, or returns to the ring base when the descriptor asks to wrap.

Several chained descriptors may form one frame. The engine tracks the running frame length, truncates any buffer that would push the frame past the configured ceiling, and reports babble when it does so. A separate limit bounds how many descriptors one kick may consume, so a ring that software has left fully ready cannot keep the engine busy without end. Per-descriptor and per-frame event pulses feed a neighbouring interrupt block.

Top module: `txring_engine`

## Requirements
- R1: A kick is accepted only when `enable` is high and `busy` is low; otherwise the engine makes no memory request and `busy` stays low.
- R2: A descriptor at word address D has flags in bits 31:16 and byte length in bits 15:0 of the word at D, and the buffer byte address in the word at D+4. Flag bit 15 is ready, bit 13 is wrap, and bit 11 is last.
- R3: A fetched descriptor whose ready bit is clear ends the walk. That descriptor is not written back and raises no event.
- R4: One kick consumes at most MAX_DESC descriptors. The following kick resumes at the descriptor after the last one consumed.
- R5: After its buffer is sent, the word at D is written back with flag bit 15 cleared and every other flag bit and the length unchanged.
- R6: The next descriptor address is the ring base when the consumed descriptor has its wrap bit set, and D+8 otherwise.
- R7: A ring base write stores the value with bits 1:0 forced to zero. When idle, it also reloads the current descriptor address, so the next walk starts there.
- R8: Buffer bytes leave in address order starting at any byte alignment. Within a memory word the byte in bits 31:24 has the lowest address. `tx_data` and `tx_last` hold steady while `tx_valid` is high and `tx_ready` is low.
- R9: `tx_last` is high only on the final byte of a buffer whose last flag is set.
- R10: When a buffer would take the frame beyond MAX_FRAME bytes, only the bytes up to MAX_FRAME are sent and `ev_babble` pulses with that descriptor's buffer event. A buffer arriving after the frame has reached the ceiling sends no bytes.
- R11: Each consumed descriptor gives one `ev_txbuf` pulse when its write-back completes. In that same cycle, `ev_txframe` pulses if its last flag is set, and the frame length count restarts at zero.
- R12: `busy` is low after reset and stays high from an accepted kick until the walk stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable (bit 1 of the control register) |
| kick | input | 1 | One-cycle transmit kick |
| ring_base_wr | input | 1 | Ring base register write strobe |
| ring_base_data | input | ADDR_W | Ring base write value |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle completion of the current request |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Downstream accepts a byte |
| ev_txbuf | output | 1 | Descriptor consumed |
| ev_txframe | output | 1 | Frame completed |
| ev_babble | output | 1 | Frame truncated at the length ceiling |
| busy | output | 1 | Walk in progress |

## Verification
The bench sweeps every buffer start alignment against lengths from one to seven under three backpressure patterns. A streamer with a wrong lane or word step would duplicate or skip bytes at word boundaries. The frame ceiling is pushed through a partial truncation and then a buffer that arrives at a full frame. A design that clipped per buffer instead of per frame would send too many bytes, and one that subtracted past the ceiling would wrap to a huge length. The descriptor limit, the stop on a non-ready entry, and the wrap return to the base are each checked by where the next kick's first read lands and by which descriptors keep their ready bit. An off-by-one limit, or a write-back to a stopped entry, would leave the ring in a visibly different state.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 16;
  localparam int FLG_READY = 15;
  localparam int FLG_WRAP  = 13;
  localparam int FLG_LAST  = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PTR,
    ST_COPY,
    ST_WB,
    ST_NEXT
  } seq_state_t;
endpackage

// File: rtl/txring_stream.sv
module txring_stream
  import txring_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  count,
  input  logic              mark_last,
  output logic              done,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready
);
  logic              busy_q, busy_d;
  logic              have_q, have_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [1:0]        lane_q, lane_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic              last_q, last_d;
  logic              take;

  assign take     = busy_q && have_q && tx_ready;
  assign done     = take && (remain_q == LEN_W'(1));
  assign mem_req  = busy_q && !have_q;
  assign mem_addr = waddr_q;
  assign tx_valid = busy_q && have_q;
  assign tx_last  = last_q && (remain_q == LEN_W'(1));

  always_comb begin
    case (lane_q)
      2'd0:    tx_data = word_q[31:24];
      2'd1:    tx_data = word_q[23:16];
      2'd2:    tx_data = word_q[15:8];
      default: tx_data = word_q[7:0];
    endcase
  end

  always_comb begin
    busy_d   = busy_q;
    have_d   = have_q;
    word_d   = word_q;
    lane_d   = lane_q;
    remain_d = remain_q;
    waddr_d  = waddr_q;
    last_d   = last_q;
    if (start) begin
      busy_d   = 1'b1;
      have_d   = 1'b0;
      waddr_d  = start_addr & ~ADDR_W'(3);
      lane_d   = start_addr[1:0];
      remain_d = count;
      last_d   = mark_last;
    end else if (mem_req && mem_ack) begin
      word_d = mem_rdata;
      have_d = 1'b1;
    end else if (take) begin
      remain_d = remain_q - LEN_W'(1);
      lane_d   = lane_q + 2'd1;
      if (remain_q == LEN_W'(1)) begin
        busy_d = 1'b0;
        have_d = 1'b0;
      end else if (lane_q == 2'd3) begin
        have_d  = 1'b0;
        waddr_d = waddr_q + ADDR_W'(4);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      have_q   <= 1'b0;
      word_q   <= '0;
      lane_q   <= '0;
      remain_q <= '0;
      waddr_q  <= '0;
      last_q   <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      have_q   <= have_d;
      word_q   <= word_d;
      lane_q   <= lane_d;
      remain_q <= remain_d;
      waddr_q  <= waddr_d;
      last_q   <= last_d;
    end
  end

  assert_hold_while_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_last_ends_buffer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last && !start) |=> !tx_valid);
endmodule

// File: rtl/txring_seq.sv
module txring_seq
  import txring_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_DESC  = 1024,
  parameter int MAX_FRAME = 2032
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic              enable,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              copy_start,
  output logic [ADDR_W-1:0] copy_addr,
  output logic [LEN_W-1:0]  copy_count,
  output logic              copy_last,
  input  logic              copy_done,
  output logic              ev_txbuf,
  output logic              ev_txframe,
  output logic              ev_babble,
  output logic              busy
);
  localparam int CNT_W = $clog2(MAX_DESC + 1);
  localparam int ACC_W = $clog2(MAX_FRAME + 1);

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [LEN_W-1:0]  flags_q, flags_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [LEN_W-1:0]  clen_q, clen_d;
  logic              bab_q, bab_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LEN_W-1:0]  room;
  logic              over;
  logic [LEN_W-1:0]  clip_len;

  assign room     = LEN_W'(MAX_FRAME) - LEN_W'(acc_q);
  assign over     = len_q > room;
  assign clip_len = over ? room : len_q;

  assign busy       = (state_q != ST_IDLE);
  assign mem_req    = (state_q == ST_HDR) || (state_q == ST_PTR) || (state_q == ST_WB);
  assign mem_we     = (state_q == ST_WB);
  assign mem_addr   = (state_q == ST_PTR) ? (cur_q + ADDR_W'(4)) : cur_q;
  assign mem_wdata  = {flags_q & ~(LEN_W'(1) << FLG_READY), len_q};
  assign copy_addr  = mem_rdata[ADDR_W-1:0];
  assign copy_count = clip_len;
  assign copy_last  = flags_q[FLG_LAST];

  always_comb begin
    state_d    = state_q;
    cur_d      = cur_q;
    base_d     = base_q;
    flags_d    = flags_q;
    len_d      = len_q;
    clen_d     = clen_q;
    bab_d      = bab_q;
    acc_d      = acc_q;
    cnt_d      = cnt_q;
    copy_start = 1'b0;
    ev_txbuf   = 1'b0;
    ev_txframe = 1'b0;
    ev_babble  = 1'b0;
    if (base_wr) begin
      base_d = base_data & ~ADDR_W'(3);
      if (state_q == ST_IDLE) cur_d = base_d;
    end
    case (state_q)
      ST_IDLE: begin
        if (kick && enable) begin
          cnt_d   = '0;
          state_d = ST_HDR;
        end
      end
      ST_HDR: begin
        if (mem_ack) begin
          flags_d = mem_rdata[WORD_W-1:LEN_W];
          len_d   = mem_rdata[LEN_W-1:0];
          state_d = mem_rdata[LEN_W+FLG_READY] ? ST_PTR : ST_IDLE;
        end
      end
      ST_PTR: begin
        if (mem_ack) begin
          clen_d = clip_len;
          bab_d  = over;
          if (clip_len == '0) begin
            state_d = ST_WB;
          end else begin
            copy_start = 1'b1;
            state_d    = ST_COPY;
          end
        end
      end
      ST_COPY: begin
        if (copy_done) state_d = ST_WB;
      end
      ST_WB: begin
        if (mem_ack) begin
          ev_txbuf   = 1'b1;
          ev_txframe = flags_q[FLG_LAST];
          ev_babble  = bab_q;
          acc_d      = flags_q[FLG_LAST] ? '0 : (acc_q + ACC_W'(clen_q));
          cnt_d      = cnt_q + CNT_W'(1);
          state_d    = ST_NEXT;
        end
      end
      ST_NEXT: begin
        if (!base_wr) cur_d = flags_q[FLG_WRAP] ? base_q : (cur_q + ADDR_W'(8));
        state_d = (cnt_q == CNT_W'(MAX_DESC)) ? ST_IDLE : ST_HDR;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      base_q  <= '0;
      flags_q <= '0;
      len_q   <= '0;
      clen_q  <= '0;
      bab_q   <= 1'b0;
      acc_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      base_q  <= base_d;
      flags_q <= flags_d;
      len_q   <= len_d;
      clen_q  <= clen_d;
      bab_q   <= bab_d;
      acc_q   <= acc_d;
      cnt_q   <= cnt_d;
    end
  end

  assert_kick_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && kick && !enable) |=> (state_q == ST_IDLE));

  assert_stop_on_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HDR && mem_ack && !mem_rdata[LEN_W+FLG_READY]) |=> (state_q == ST_IDLE));

  assert_desc_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_DESC));

  assert_frame_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= ACC_W'(MAX_FRAME));
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txring_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_DESC  = 1024,
  parameter int MAX_FRAME = 2032
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              kick,
  input  logic              ring_base_wr,
  input  logic [ADDR_W-1:0] ring_base_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              ev_txbuf,
  output logic              ev_txframe,
  output logic              ev_babble,
  output logic              busy
);
  logic              seq_req, seq_we, seq_ack;
  logic [ADDR_W-1:0] seq_addr;
  logic [31:0]       seq_wdata;
  logic              st_req, st_ack;
  logic [ADDR_W-1:0] st_addr;
  logic              cp_start, cp_last, cp_done;
  logic [ADDR_W-1:0] cp_addr;
  logic [LEN_W-1:0]  cp_count;

  assign seq_ack   = mem_ack && seq_req;
  assign st_ack    = mem_ack && st_req;
  assign mem_req   = seq_req || st_req;
  assign mem_we    = seq_req && seq_we;
  assign mem_addr  = seq_req ? seq_addr : st_addr;
  assign mem_wdata = seq_wdata;

  txring_seq #(
    .ADDR_W   (ADDR_W),
    .MAX_DESC (MAX_DESC),
    .MAX_FRAME(MAX_FRAME)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick      (kick),
    .enable    (enable),
    .base_wr   (ring_base_wr),
    .base_data (ring_base_data),
    .mem_req   (seq_req),
    .mem_we    (seq_we),
    .mem_addr  (seq_addr),
    .mem_wdata (seq_wdata),
    .mem_ack   (seq_ack),
    .mem_rdata (mem_rdata),
    .copy_start(cp_start),
    .copy_addr (cp_addr),
    .copy_count(cp_count),
    .copy_last (cp_last),
    .copy_done (cp_done),
    .ev_txbuf  (ev_txbuf),
    .ev_txframe(ev_txframe),
    .ev_babble (ev_babble),
    .busy      (busy)
  );

  txring_stream #(
    .ADDR_W(ADDR_W)
  ) stream_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cp_start),
    .start_addr(cp_addr),
    .count     (cp_count),
    .mark_last (cp_last),
    .done      (cp_done),
    .mem_req   (st_req),
    .mem_addr  (st_addr),
    .mem_ack   (st_ack),
    .mem_rdata (mem_rdata),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_ready  (tx_ready)
  );

  assert_one_master: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_req && st_req));

  assert_wb_clears_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[16+FLG_READY]);

  assert_frame_event_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txframe |-> ev_txbuf);

  assert_no_stream_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid);
endmodule

// File: tb/txring_engine_tb_top.sv
module txring_engine_tb_top;
  localparam int MD = 4;
  localparam int MF = 20;

  logic        clk, rst_n;
  logic        enable, kick, ring_base_wr;
  logic [31:0] ring_base_data;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_last, tx_ready;
  logic [7:0]  tx_data;
  logic        ev_txbuf, ev_txframe, ev_babble, busy;

  txring_engine #(.ADDR_W(32), .MAX_DESC(MD), .MAX_FRAME(MF)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .kick(kick),
    .ring_base_wr(ring_base_wr), .ring_base_data(ring_base_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .ev_txbuf(ev_txbuf), .ev_txframe(ev_txframe), .ev_babble(ev_babble), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [31:0] mem [0:127];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[8:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[8:2]];
    end
  end

  int rmode = 0;
  logic [7:0] cap_d [0:63];
  logic       cap_l [0:63];
  int cap_n, n_buf, n_frame, n_bab, req_cycles;
  logic first_seen, busy_seen;
  logic [31:0] first_addr;

  always @(negedge clk) begin
    logic r;
    cyc++;
    case (rmode)
      0: r = 1'b1;
      1: r = cyc[0];
      default: r = (cyc % 3) != 0;
    endcase
    if (tx_valid && r && cap_n < 64) begin
      cap_d[cap_n] = tx_data;
      cap_l[cap_n] = tx_last;
      cap_n++;
    end
    tx_ready <= r;
    if (ev_txbuf) n_buf++;
    if (ev_txframe) n_frame++;
    if (ev_babble) n_bab++;
    if (busy) busy_seen = 1'b1;
    if (mem_req) begin
      req_cycles++;
      if (!first_seen) begin
        first_seen = 1'b1;
        first_addr = mem_addr;
      end
    end
  end

  initial begin
    #600000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [7:0] bval(int a);
    return 8'((a * 13) + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] exp_d [0:63];
  logic       exp_l [0:63];
  int exp_n;

  task automatic exp_seg(input int p, input int n, input bit last);
    for (int i = 0; i < n; i++) begin
      exp_d[exp_n] = bval(p + i);
      exp_l[exp_n] = last && (i == n - 1);
      exp_n++;
    end
  endtask

  task automatic cmp_stream(input string tag);
    int bad_d = 0;
    int bad_l = 0;
    chk(cap_n == exp_n, {tag, " R8 byte count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      if (cap_d[i] != exp_d[i]) bad_d++;
      if (cap_l[i] != exp_l[i]) bad_l++;
    end
    chk(bad_d == 0, {tag, " R8 byte values"}, bad_d, 0);
    chk(bad_l == 0, {tag, " R9 last marks"}, bad_l, 0);
  endtask

  task automatic set_desc(input int a, input logic [15:0] fl, input logic [15:0] ln, input int p);
    mem[a >> 2]       = {fl, ln};
    mem[(a >> 2) + 1] = 32'(p);
  endtask

  task automatic base_write(input logic [31:0] v);
    @(negedge clk);
    ring_base_wr   = 1'b1;
    ring_base_data = v;
    @(negedge clk);
    ring_base_wr = 1'b0;
  endtask

  task automatic run_kick();
    cap_n = 0; n_buf = 0; n_frame = 0; n_bab = 0; req_cycles = 0;
    first_seen = 1'b0; busy_seen = 1'b0;
    @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; kick = 1'b0; ring_base_wr = 1'b0; ring_base_data = '0;
    tx_ready = 1'b1;
    cap_n = 0; n_buf = 0; n_frame = 0; n_bab = 0; req_cycles = 0;
    first_seen = 1'b0; busy_seen = 1'b0; first_addr = '0;
    for (int w = 0; w < 128; w++)
      mem[w] = {bval(4*w), bval(4*w+1), bval(4*w+2), bval(4*w+3)};
    repeat (4) @(negedge clk);
    chk(!busy && !tx_valid && !mem_req, "R12 reset idle", {busy, tx_valid, mem_req}, 0);
    chk(!ev_txbuf && !ev_txframe && !ev_babble, "R11 reset events", {ev_txbuf, ev_txframe, ev_babble}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: kick while disabled
    set_desc(0, 16'h8800, 16'd2, 'h100);
    run_kick();
    chk(req_cycles == 0, "R1 no memory access when disabled", req_cycles, 0);
    chk(!busy_seen, "R1 busy stays low", busy_seen, 0);
    enable = 1'b1;

    // R2 R3 R5 R7: two-buffer frame, stop on non-ready
    set_desc('h40, 16'h8000, 16'd5, 'h101);
    set_desc('h48, 16'h8800, 16'd3, 'h10A);
    set_desc('h50, 16'h0000, 16'd7, 'h100);
    base_write(32'h43);
    exp_n = 0; exp_seg('h101, 5, 1'b0); exp_seg('h10A, 3, 1'b1);
    run_kick();
    chk(busy_seen, "R12 busy during walk", busy_seen, 1);
    chk(first_addr == 32'h40, "R7 base low bits cleared", first_addr, 32'h40);
    cmp_stream("chain R2");
    chk(n_buf == 2 && n_frame == 1 && n_bab == 0, "R11 R3 events", {n_buf, n_frame, n_bab}, {32'd2, 32'd1, 32'd0});
    chk(mem['h40 >> 2] == {16'h0000, 16'd5}, "R5 writeback first", mem['h40 >> 2], {16'h0000, 16'd5});
    chk(mem['h48 >> 2] == {16'h0800, 16'd3}, "R5 writeback second", mem['h48 >> 2], {16'h0800, 16'd3});
    chk(mem['h50 >> 2] == {16'h0000, 16'd7}, "R3 stopped entry untouched", mem['h50 >> 2], {16'h0000, 16'd7});

    // R6: continuation then wrap
    set_desc('h50, 16'hA800, 16'd4, 'h123);
    exp_n = 0; exp_seg('h123, 4, 1'b1);
    run_kick();
    chk(first_addr == 32'h50, "R6 resume at D+8", first_addr, 32'h50);
    cmp_stream("wrap R6");
    chk(n_buf == 1, "R3 stop after wrap", n_buf, 1);
    set_desc('h40, 16'h8800, 16'd2, 'h130);
    exp_n = 0; exp_seg('h130, 2, 1'b1);
    run_kick();
    chk(first_addr == 32'h40, "R6 wrap to base", first_addr, 32'h40);
    cmp_stream("after wrap R6");

    // R4: descriptor limit per kick
    for (int i = 0; i < 6; i++) set_desc('h40 + 8*i, 16'h8800, 16'd1, 'h140 + i);
    set_desc('h70, 16'h0000, 16'd1, 'h140);
    base_write(32'h40);
    exp_n = 0;
    for (int i = 0; i < 4; i++) exp_seg('h140 + i, 1, 1'b1);
    run_kick();
    chk(n_buf == MD, "R4 limit consumed", n_buf, MD);
    cmp_stream("limit R4");
    chk(mem['h60 >> 2][31] == 1'b1, "R4 fifth still ready", mem['h60 >> 2][31], 1);
    run_kick();
    chk(n_buf == 2 && first_addr == 32'h60, "R4 resume", {n_buf, first_addr}, {32'd2, 32'h60});

    // R10: truncation with babble
    base_write(32'h80);
    set_desc('h80, 16'h8000, 16'd12, 'h100);
    set_desc('h88, 16'h8800, 16'd12, 'h110);
    set_desc('h90, 16'h0000, 16'd0, 'h100);
    exp_n = 0; exp_seg('h100, 12, 1'b0); exp_seg('h110, 8, 1'b1);
    run_kick();
    cmp_stream("cap R10");
    chk(n_bab == 1 && n_buf == 2 && n_frame == 1, "R10 babble once", {n_bab, n_buf, n_frame}, {32'd1, 32'd2, 32'd1});
    chk(mem['h88 >> 2] == {16'h0800, 16'd12}, "R5 length kept after clip", mem['h88 >> 2], {16'h0800, 16'd12});

    // R10 R11: buffer past a full frame, then fresh frame
    base_write(32'h80);
    rmode = 1;
    set_desc('h80, 16'h8000, 16'd12, 'h100);
    set_desc('h88, 16'h8000, 16'd12, 'h110);
    set_desc('h90, 16'h8800, 16'd5, 'h120);
    set_desc('h98, 16'h8800, 16'd3, 'h150);
    exp_n = 0; exp_seg('h100, 12, 1'b0); exp_seg('h110, 8, 1'b0); exp_seg('h150, 3, 1'b1);
    run_kick();
    cmp_stream("full frame R10");
    chk(n_bab == 2 && n_buf == 4 && n_frame == 2, "R11 accumulator reset", {n_bab, n_buf, n_frame}, {32'd2, 32'd4, 32'd2});

    // R8 sweep: alignment x length x backpressure
    base_write(32'hC0);
    for (int off = 0; off < 4; off++) begin
      for (int ln = 1; ln <= 7; ln++) begin
        rmode = (off + ln) % 3;
        set_desc('hC0, 16'hA800, 16'(ln), 'h140 + off);
        exp_n = 0; exp_seg('h140 + off, ln, 1'b1);
        run_kick();
        cmp_stream($sformatf("sweep off=%0d len=%0d", off, ln));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule